// File: doc/BRIEF.md
# Per-Core Fast-Interrupt Source Combiner

This block gathers the local fast-interrupt sources of one processor core and folds them into a single level-sensitive request line. The sources are a pending flag for fast inter-processor interrupts, four architectural timers, a core performance-counter overflow flag and an uncore performance-counter interrupt. The timers are a host physical timer, a host virtual timer, a guest physical timer and a guest virtual timer. Next to the request, the block drives a registered status vector with one bit per source. Software polls every source on each entry, so there is no priority encoder and no vector number.

The block holds three pieces of control state. The first is the fast-IPI pending flag. It is set by an arrival pulse and cleared by software writing a one. The second is a two-bit guest-timer enable register. The third is a 32-bit uncore counter control word, which carries an interrupt-mode field. The timer control/status words, the counter flags and the IPI network are plain inputs from elsewhere in the core. Every pin is a plain control or status signal. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. A write is taken on any clock edge where `wr_en` is high.

Top module: `fiq_source_combiner`

## Requirements
- R1: Host timers: status bit 1 (host physical, `tmr_ctl[2:0]`) and bit 2 (host virtual, `tmr_ctl[5:3]`) are set one cycle after the sampled control word has enable (bit 0) = 1, status (bit 2) = 1 and mask (bit 1) = 0. Every other pattern leaves the bit clear.
- R2: Guest timers: status bit 3 (guest physical, `tmr_ctl[8:6]`) also needs guest-enable bit 1, and status bit 4 (guest virtual, `tmr_ctl[11:9]`) also needs guest-enable bit 0. Both must meet the R1 pattern as well.
- R3: While `hyp_mode` is low, status bits 3 and 4 stay clear whatever the guest timers and the guest-enable register hold.
- R4: Status bit 5 follows `core_pmc_act` with one cycle of latency.
- R5: The IPI pending flag is set by `ipi_arrive`. It is cleared by a write to address 0 with data bit 0 = 1, and a write with bit 0 = 0 leaves it unchanged. When an arrival and a clear fall in the same cycle, the arrival wins. Status bit 0 shows the flag one cycle after the flag itself changes.
- R6: The uncore mode is `uncore_ctl[18:16]`, with 0 = off, 2 = main controller, 3 = halt and 4 = fast interrupt. Status bit 6 is set only when this mode is 4 and `uncore_act` is 1. Every other mode value blocks the source.
- R7: `fiq_req` is high in exactly the cycles in which the status vector is non-zero, so it is the level OR of all qualified sources.
- R8: Address 1 loads `guest_tmr_en` from data bits 1:0 and address 2 loads the full `uncore_ctl` word. Both show on the outputs the cycle after the write. A register's new value affects the status one cycle after that. A write to address 3 changes nothing.
- R9: During reset all outputs are zero: status, request, pending flag, guest enables and uncore control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hyp_mode | input | 1 | Core runs in hypervisor mode |
| ipi_arrive | input | 1 | Fast-IPI arrival pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 IPI clear, 1 guest enable, 2 uncore control |
| wr_data | input | 32 | Write data |
| tmr_ctl | input | 12 | Four 3-bit timer control/status words |
| core_pmc_act | input | 1 | Core counter interrupt active |
| uncore_act | input | 1 | Uncore counter interrupt active |
| fiq_req | output | 1 | Combined fast-interrupt request |
| src_status | output | 7 | Per-source asserting vector |
| ipi_pending | output | 1 | Fast-IPI pending flag |
| guest_tmr_en | output | 2 | Guest-timer enable register |
| uncore_ctl | output | 32 | Uncore counter control word |

## Verification
Inputs sampled at an edge appear in `src_status` and `fiq_req` right after that edge. A register write or an IPI arrival first updates its register at that edge, and it reaches the status vector one edge later. The bench keeps a behavioural model that is updated at each rising edge, using the pre-edge register values in exactly that order. It compares every output a quarter period after the edge, when the outputs have settled and no input is moving. Inputs change only on falling edges, so no sample depends on the order of processes at a clock edge.

// File: rtl/fiq_comb_pkg.sv
package fiq_comb_pkg;
  localparam int NUM_TMR   = 4;
  localparam int TMR_CTL_W = 3;
  localparam int CTL_EN    = 0;
  localparam int CTL_MASK  = 1;
  localparam int CTL_STAT  = 2;

  localparam int SRC_IPI   = 0;
  localparam int SRC_TMR0  = 1;
  localparam int SRC_CPMC  = SRC_TMR0 + NUM_TMR;
  localparam int SRC_UPMC  = SRC_CPMC + 1;
  localparam int NUM_SRC   = SRC_UPMC + 1;

  // timer slot order inside tmr_ctl
  localparam int TMR_HOST_PHYS  = 0;
  localparam int TMR_HOST_VIRT  = 1;
  localparam int TMR_GUEST_PHYS = 2;
  localparam int TMR_GUEST_VIRT = 3;

  // guest enable register bits
  localparam int GEN_VIRT = 0;
  localparam int GEN_PHYS = 1;

  localparam logic [1:0] ADDR_IPI   = 2'd0;
  localparam logic [1:0] ADDR_GUEST = 2'd1;
  localparam logic [1:0] ADDR_UNC   = 2'd2;

  typedef enum logic [2:0] {
    UMODE_OFF  = 3'd0,
    UMODE_MAIN = 3'd2,
    UMODE_HALT = 3'd3,
    UMODE_FIQ  = 3'd4
  } umode_e;
endpackage

// File: rtl/fiq_timer_qual.sv
module fiq_timer_qual
  import fiq_comb_pkg::*;
(
  input  logic [TMR_CTL_W-1:0] ctl,
  input  logic                 gate,
  output logic                 fire
);
  logic pattern_ok;

  always_comb begin
    pattern_ok = ctl[CTL_EN] & ctl[CTL_STAT] & ~ctl[CTL_MASK];
    fire       = pattern_ok & gate;
  end
endmodule

// File: rtl/fiq_ctrl_regs.sv
module fiq_ctrl_regs
  import fiq_comb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ipi_arrive,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ipi_pending,
  output logic [1:0]        guest_en,
  output logic [DATA_W-1:0] unc_ctl
);
  logic ipi_clr;
  logic gen_we;
  logic unc_we;

  always_comb begin
    ipi_clr = wr_en && (wr_addr == ADDR_IPI) && wr_data[0];
    gen_we  = wr_en && (wr_addr == ADDR_GUEST);
    unc_we  = wr_en && (wr_addr == ADDR_UNC);
  end

  // arrival has precedence over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ipi_pending <= 1'b0;
    else if (ipi_arrive) ipi_pending <= 1'b1;
    else if (ipi_clr)    ipi_pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      guest_en <= '0;
    else if (gen_we) guest_en <= wr_data[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unc_ctl <= '0;
    else if (unc_we) unc_ctl <= wr_data;
  end
endmodule

// File: rtl/fiq_uncore_qual.sv
module fiq_uncore_qual
  import fiq_comb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MODE_LSB = 16,
  parameter int MODE_W   = 3
) (
  input  logic [DATA_W-1:0] ctl_word,
  input  logic              active,
  output logic              fire
);
  logic [MODE_W-1:0] mode;

  always_comb begin
    mode = ctl_word[MODE_LSB +: MODE_W];
    fire = active && (mode == MODE_W'(UMODE_FIQ));
  end
endmodule

// File: rtl/fiq_source_combiner.sv
module fiq_source_combiner
  import fiq_comb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MODE_LSB = 16,
  parameter int MODE_W   = 3,
  localparam int TMR_W   = NUM_TMR * TMR_CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hyp_mode,
  input  logic              ipi_arrive,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TMR_W-1:0]  tmr_ctl,
  input  logic              core_pmc_act,
  input  logic              uncore_act,
  output logic              fiq_req,
  output logic [NUM_SRC-1:0] src_status,
  output logic              ipi_pending,
  output logic [1:0]        guest_tmr_en,
  output logic [DATA_W-1:0] uncore_ctl
);
  logic [NUM_TMR-1:0] tmr_gate;
  logic [NUM_TMR-1:0] tmr_fire;
  logic               unc_fire;
  logic [NUM_SRC-1:0] status_nxt;

  fiq_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ipi_arrive  (ipi_arrive),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .ipi_pending (ipi_pending),
    .guest_en    (guest_tmr_en),
    .unc_ctl     (uncore_ctl)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    if (t == TMR_GUEST_PHYS) begin : g_gphys
      assign tmr_gate[t] = hyp_mode & guest_tmr_en[GEN_PHYS];
    end else if (t == TMR_GUEST_VIRT) begin : g_gvirt
      assign tmr_gate[t] = hyp_mode & guest_tmr_en[GEN_VIRT];
    end else begin : g_host
      assign tmr_gate[t] = 1'b1;
    end
    fiq_timer_qual u_tq (
      .ctl  (tmr_ctl[t*TMR_CTL_W +: TMR_CTL_W]),
      .gate (tmr_gate[t]),
      .fire (tmr_fire[t])
    );
  end

  fiq_uncore_qual #(
    .DATA_W   (DATA_W),
    .MODE_LSB (MODE_LSB),
    .MODE_W   (MODE_W)
  ) u_unc (
    .ctl_word (uncore_ctl),
    .active   (uncore_act),
    .fire     (unc_fire)
  );

  always_comb begin
    status_nxt                           = '0;
    status_nxt[SRC_IPI]                  = ipi_pending;
    status_nxt[SRC_TMR0 +: NUM_TMR]      = tmr_fire;
    status_nxt[SRC_CPMC]                 = core_pmc_act;
    status_nxt[SRC_UPMC]                 = unc_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_status <= '0;
      fiq_req    <= 1'b0;
    end else begin
      src_status <= status_nxt;
      fiq_req    <= |status_nxt;
    end
  end
endmodule

// File: rtl/fiq_combiner_chk.sv
module fiq_combiner_chk
  import fiq_comb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MODE_LSB = 16,
  parameter int MODE_W   = 3,
  localparam int TMR_W   = NUM_TMR * TMR_CTL_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hyp_mode,
  input logic               ipi_arrive,
  input logic               wr_en,
  input logic [1:0]         wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic [TMR_W-1:0]   tmr_ctl,
  input logic               core_pmc_act,
  input logic               uncore_act,
  input logic               fiq_req,
  input logic [NUM_SRC-1:0] src_status,
  input logic               ipi_pending,
  input logic [1:0]         guest_tmr_en,
  input logic [DATA_W-1:0]  uncore_ctl
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_host_timer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (src_status[SRC_TMR0] ==
              ($past(tmr_ctl[CTL_EN]) && $past(tmr_ctl[CTL_STAT]) && !$past(tmr_ctl[CTL_MASK]))));

  assert_guest_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && src_status[SRC_TMR0 + TMR_GUEST_PHYS]) |-> $past(guest_tmr_en[GEN_PHYS]));

  assert_hyp_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(hyp_mode)) |->
      !src_status[SRC_TMR0 + TMR_GUEST_PHYS] && !src_status[SRC_TMR0 + TMR_GUEST_VIRT]);

  assert_core_pmc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (src_status[SRC_CPMC] == $past(core_pmc_act)));

  assert_ipi_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(wr_en && wr_addr == ADDR_IPI && wr_data[0] && !ipi_arrive)) |-> !ipi_pending);

  assert_ipi_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(ipi_arrive)) |-> ipi_pending);

  assert_uncore_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && src_status[SRC_UPMC]) |->
      ($past(uncore_ctl[MODE_LSB +: MODE_W]) == MODE_W'(UMODE_FIQ)) && $past(uncore_act));

  assert_req_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req == (src_status != '0));
endmodule

bind fiq_source_combiner fiq_combiner_chk #(
  .DATA_W   (DATA_W),
  .MODE_LSB (MODE_LSB),
  .MODE_W   (MODE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hyp_mode     (hyp_mode),
  .ipi_arrive   (ipi_arrive),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .tmr_ctl      (tmr_ctl),
  .core_pmc_act (core_pmc_act),
  .uncore_act   (uncore_act),
  .fiq_req      (fiq_req),
  .src_status   (src_status),
  .ipi_pending  (ipi_pending),
  .guest_tmr_en (guest_tmr_en),
  .uncore_ctl   (uncore_ctl)
);

// File: tb/sim_fiq_source_combiner.sv
module sim_fiq_source_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        hyp_mode = 1'b0;
  logic        ipi_arrive = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [11:0] tmr_ctl = '0;
  logic        core_pmc_act = 1'b0;
  logic        uncore_act = 1'b0;
  logic        fiq_req;
  logic [6:0]  src_status;
  logic        ipi_pending;
  logic [1:0]  guest_tmr_en;
  logic [31:0] uncore_ctl;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit started = 0;

  // reference model state
  bit        m_pend;
  bit [1:0]  m_gen;
  bit [31:0] m_uctl;
  bit [6:0]  m_stat;
  bit        m_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  fiq_source_combiner u0 (
    .clk(clk), .rst_n(rst_n), .hyp_mode(hyp_mode), .ipi_arrive(ipi_arrive),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tmr_ctl(tmr_ctl),
    .core_pmc_act(core_pmc_act), .uncore_act(uncore_act), .fiq_req(fiq_req),
    .src_status(src_status), .ipi_pending(ipi_pending),
    .guest_tmr_en(guest_tmr_en), .uncore_ctl(uncore_ctl)
  );

  function automatic bit fires(input logic [2:0] c);
    return (c == 3'b101);   // enable=1, mask=0, status=1
  endfunction

  function automatic string tag_of(input int b);
    case (b)
      0: return "R5";
      1, 2: return "R1";
      3, 4: return "R2/R3";
      5: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_gen = 0; m_uctl = 0; m_stat = 0; m_req = 0;
    end else begin
      m_stat[0] = m_pend;
      m_stat[1] = fires(tmr_ctl[2:0]);
      m_stat[2] = fires(tmr_ctl[5:3]);
      m_stat[3] = hyp_mode && m_gen[1] && fires(tmr_ctl[8:6]);
      m_stat[4] = hyp_mode && m_gen[0] && fires(tmr_ctl[11:9]);
      m_stat[5] = core_pmc_act;
      m_stat[6] = uncore_act && (m_uctl[18:16] == 3'd4);
      m_req = (m_stat != 0);
      if (ipi_arrive) m_pend = 1;
      else if (wr_en && wr_addr == 2'd0 && wr_data[0]) m_pend = 0;
      if (wr_en && wr_addr == 2'd1) m_gen = wr_data[1:0];
      if (wr_en && wr_addr == 2'd2) m_uctl = wr_data;
    end
    #(CLK_PERIOD/4);
    if (started && !done) begin
      if (!rst_n) begin
        check("R9", "reset outputs", {src_status, fiq_req, ipi_pending, guest_tmr_en}, 0);
        check("R9", "reset uncore_ctl", uncore_ctl, 0);
      end else begin
        for (int b = 0; b < 7; b++)
          if (src_status[b] !== m_stat[b])
            check(tag_of(b), $sformatf("src_status[%0d]", b), src_status[b], m_stat[b]);
          else n_cmp++;
        check("R7", "fiq_req", fiq_req, m_req);
        check("R5", "ipi_pending", ipi_pending, m_pend);
        check("R8", "guest_tmr_en", guest_tmr_en, m_gen);
        check("R8", "uncore_ctl", uncore_ctl, m_uctl);
      end
    end
  end

  task automatic idle_inputs();
    ipi_arrive = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idle_inputs();
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    idle_inputs();
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #1 rst_n = 0;
    started = 1;
    step(3);
    rst_n = 1;
    step(2);
    // R1: every control pattern on each host timer
    for (int t = 0; t < 2; t++)
      for (int p = 0; p < 8; p++) begin
        @(negedge clk); tmr_ctl = '0; tmr_ctl[t*3 +: 3] = 3'(p);
        step(1);
      end
    // R2/R3: guest timers under each gate combination
    for (int h = 0; h < 2; h++)
      for (int g = 0; g < 4; g++) begin
        @(negedge clk); hyp_mode = h[0];
        wr(2'd1, 32'(g));
        for (int p = 0; p < 8; p++) begin
          @(negedge clk); tmr_ctl = {3'(p), 3'(7 - p), 6'b0};
          step(2);
        end
      end
    tmr_ctl = '0;
    // R4
    @(negedge clk); core_pmc_act = 1; step(2);
    @(negedge clk); core_pmc_act = 0; step(2);
    // R6: every mode value with the active flag both ways
    for (int m = 0; m < 8; m++) begin
      wr(2'd2, {13'h1abc, 3'(m), 16'h5a5a});
      @(negedge clk); uncore_act = 1; step(2);
      @(negedge clk); uncore_act = 0; step(1);
    end
    // R5: arrival, write of zero, clear, arrival against clear
    @(negedge clk); ipi_arrive = 1; step(2);
    wr(2'd0, 32'hffff_fffe); step(2);
    wr(2'd0, 32'h1); step(2);
    @(negedge clk); ipi_arrive = 1; wr_en = 1; wr_addr = 2'd0; wr_data = 32'h1;
    step(3);
    // R8: address 3 is ignored
    wr(2'd3, 32'hffff_ffff); step(2);
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      ipi_arrive   = ($urandom_range(0, 7) == 0);
      wr_en        = ($urandom_range(0, 3) == 0);
      wr_addr      = 2'($urandom_range(0, 3));
      wr_data      = $urandom;
      if ($urandom_range(0, 1) == 1) wr_data[18:16] = 3'd4;
      tmr_ctl      = 12'($urandom);
      hyp_mode     = ($urandom_range(0, 3) != 0);
      core_pmc_act = $urandom_range(0, 1) == 1;
      uncore_act   = $urandom_range(0, 1) == 1;
    end
    step(3);
    // R9: reset in the middle of activity
    @(negedge clk); rst_n = 0; step(2);
    @(negedge clk); rst_n = 1; step(3);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule